// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block turns a fast core clock into the bit timing of an I2C master. A programmable divider sets the SCL period in core clocks. The low half and the high half of each period are equal. Two programmable delays place two strobes within every bit. The update strobe tells a byte-level engine when to drive its next data bit, counted from the falling SCL edge. The sample strobe tells it when to capture the incoming bit, counted from the rising SCL edge.

The block drives SCL as an open-drain level: `scl_out` low means pull the line low, and high means release it. It reads the line back on `scl_in`. When the line stays low after release, a target is stretching the clock. The high phase then pauses, and a sticky timeout flag rises once the stretch has lasted a programmed number of core clocks. Dropping the enable releases SCL and returns every counter to zero. Byte sequencing, addressing and buffering belong to the engine that uses these strobes.

Top module: `scl_timing_gen`

## Requirements
- R1: The effective divider D is `div_val` with bit 0 cleared, and programmed values 0 and 1 act as 2. With no stretching, SCL is low for D/2 core clocks and then high for D/2 core clocks, repeating.
- R2: When `en` is first sampled high, `scl_out` goes low one clock later, so every run starts with a falling edge.
- R3: `upd_stb` is a one-clock pulse in the cycle that lies F core clocks after each falling edge, where cycle 0 is the first low cycle and F is the clamped fall delay.
- R4: `smp_stb` is a one-clock pulse in the cycle that lies S core clocks after the rising edge, where cycle 0 is the first released cycle in which `scl_in` reads high and S is the clamped rise delay.
- R5: The delay word `dly_word` carries the fall delay in bits 31:16 and the rise delay in bits 15:0. Each delay of 0 is used as 1, and each delay above D/2 is used as D/2.
- R6: While SCL is released but `scl_in` reads low, the high-phase count stands still, `scl_out` stays high and no sample strobe is issued.
- R7: With a stretch limit L above 0, `stretch_to` rises L clocks after the first stalled cycle of a continuous stretch. It then stays high until `en` drops. When L is 0, it never rises, and a stretch shorter than L does not raise it.
- R8: When `en` is low, one clock later `scl_out` is high, both strobes and `stretch_to` are low, and all counts are zero.
- R9: `upd_stb` and `smp_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases SCL and clears all counts |
| div_val | input | 16 | SCL period in core clocks (bit 0 ignored) |
| dly_word | input | 32 | Fall delay in 31:16, rise delay in 15:0 |
| stretch_lim | input | 16 | Stretch timeout in core clocks (0 disables) |
| scl_in | input | 1 | Sensed SCL line level |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| upd_stb | output | 1 | Pulse: put out the next data bit |
| smp_stb | output | 1 | Pulse: sample the incoming data bit |
| stretch_to | output | 1 | Sticky clock-stretch timeout flag |

## Verification
The hardest case to reach is a target holding SCL low after release. At that point the high-phase count must freeze, the sample strobe must wait for the real rising edge, and the timeout must land on an exact clock. The bench forms `scl_in` as `scl_out` gated by a hold signal. It asserts the hold across the release so that the stall starts on a known cycle, and it drops the hold on a chosen cycle. The stall lengths tested are shorter than the limit, longer than the limit, and run with the limit at zero. Separately, a sweep over every small divider and every pair of small delays checks each cycle of SCL and both strobes against a period-modulo model. That sweep includes the clamp boundaries at 0 and at D/2.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Half of the effective divider: bit 0 dropped, never below one.
    function automatic logic [31:0] half_of(input logic [31:0] div);
        logic [31:0] h;
        h = div >> 1;
        if (h == 32'd0) h = 32'd1;
        return h;
    endfunction

    // Clamp a delay into the range 1 .. half.
    function automatic logic [31:0] clamp_dly(input logic [31:0] dly,
                                              input logic [31:0] half);
        logic [31:0] d;
        d = (dly == 32'd0) ? 32'd1 : dly;
        if (d > half) d = half;
        return d;
    endfunction

endpackage

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
    import scl_tim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] half,
    input  logic             scl_in,
    output scl_phase_e       phase,
    output logic [CNT_W-1:0] cnt,
    output logic             stall
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic last_tick;
    assign last_tick = (cnt >= half - ONE);
    assign stall     = (phase == PH_HIGH) && !scl_in;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if (last_tick) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_HIGH: begin
                    if (scl_in) begin
                        if (last_tick) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/scl_strobe.sv
module scl_strobe
    import scl_tim_pkg::*;
#(
    parameter int         CNT_W    = 16,
    parameter scl_phase_e WATCH_PH = PH_LOW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  scl_phase_e       phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] dly,
    input  logic             scl_in,
    output logic             stb
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic line_ok;
    logic hit;

    generate
        if (WATCH_PH == PH_HIGH) begin : g_need_line
            assign line_ok = scl_in;
        end else begin : g_no_line
            assign line_ok = 1'b1;
        end
    endgenerate

    assign hit = (phase == WATCH_PH) && line_ok && (cnt == dly - ONE);

    always_ff @(posedge clk) begin
        if (rst || !en) stb <= 1'b0;
        else            stb <= hit;
    end

endmodule

// File: rtl/scl_stretch_mon.sv
module scl_stretch_mon #(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             stall,
    input  logic [LIM_W-1:0] lim,
    output logic             flag
);

    localparam logic [LIM_W-1:0] ONE = LIM_W'(1);

    logic [LIM_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else begin
            if (stall) begin
                if (run_cnt != '1) run_cnt <= run_cnt + ONE;
            end else begin
                run_cnt <= '0;
            end
            if (stall && (lim != '0) && (run_cnt == lim - ONE)) flag <= 1'b1;
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tim_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int LIM_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [DIV_W-1:0]   div_val,
    input  logic [2*DIV_W-1:0] dly_word,
    input  logic [LIM_W-1:0]   stretch_lim,
    input  logic               scl_in,
    output logic               scl_out,
    output logic               upd_stb,
    output logic               smp_stb,
    output logic               stretch_to
);

    localparam int NUM_STB = 2;

    logic [DIV_W-1:0] half_c;
    logic [DIV_W-1:0] dly_c [NUM_STB];
    logic [DIV_W-1:0] dly_raw [NUM_STB];
    logic [NUM_STB-1:0] stb_v;

    scl_phase_e       phase;
    logic [DIV_W-1:0] cnt;
    logic             stall;

    assign half_c     = DIV_W'(half_of(32'(div_val)));
    assign dly_raw[0] = dly_word[2*DIV_W-1:DIV_W];
    assign dly_raw[1] = dly_word[DIV_W-1:0];

    scl_phase_ctr #(.CNT_W(DIV_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .half   (half_c),
        .scl_in (scl_in),
        .phase  (phase),
        .cnt    (cnt),
        .stall  (stall)
    );

    generate
        for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
            localparam scl_phase_e PH = (i == 0) ? PH_LOW : PH_HIGH;
            assign dly_c[i] = DIV_W'(clamp_dly(32'(dly_raw[i]), 32'(half_c)));
            scl_strobe #(.CNT_W(DIV_W), .WATCH_PH(PH)) u_stb (
                .clk    (clk),
                .rst    (rst),
                .en     (en),
                .phase  (phase),
                .cnt    (cnt),
                .dly    (dly_c[i]),
                .scl_in (scl_in),
                .stb    (stb_v[i])
            );
        end
    endgenerate

    scl_stretch_mon #(.LIM_W(LIM_W)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .stall (stall),
        .lim   (stretch_lim),
        .flag  (stretch_to)
    );

    assign scl_out = (phase != PH_LOW);
    assign upd_stb = stb_v[0];
    assign smp_stb = stb_v[1];

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic scl_in,
    input logic scl_out,
    input logic upd_stb,
    input logic smp_stb,
    input logic stretch_to
);

    // R8
    disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (scl_out && !upd_stb && !smp_stb && !stretch_to));

    // R9
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(upd_stb && smp_stb));

    // R4
    sample_after_high_chk: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> ($past(scl_in) && $past(scl_out)));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stretch_to && en) |=> stretch_to);

    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stretch_to) |-> $past(scl_out && !scl_in));

    // R2
    start_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(en) && !$past(rst)) |=> !scl_out);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_out && !scl_in && en && $past(en) && !$past(rst)) |=> scl_out);

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .scl_in     (scl_in),
    .scl_out    (scl_out),
    .upd_stb    (upd_stb),
    .smp_stb    (smp_stb),
    .stretch_to (stretch_to)
);

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] div_val = 16'd4;
    logic [31:0] dly_word = 32'h0001_0001;
    logic [15:0] stretch_lim = 16'd0;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        scl_out, upd_stb, smp_stb, stretch_to;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    assign scl_in = scl_out & ~hold;

    always #10 clk = ~clk;

    scl_timing_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .div_val     (div_val),
        .dly_word    (dly_word),
        .stretch_lim (stretch_lim),
        .scl_in      (scl_in),
        .scl_out     (scl_out),
        .upd_stb     (upd_stb),
        .smp_stb     (smp_stb),
        .stretch_to  (stretch_to)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    // Advance one clock and land on the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic disable_and_check();
        en = 1'b0;
        step();
        check(scl_out == 1'b1, "R8 scl released", int'(scl_out), 1);
        check(!upd_stb && !smp_stb, "R8 strobes idle", int'(upd_stb) + int'(smp_stb), 0);
        check(stretch_to == 1'b0, "R8 flag cleared", int'(stretch_to), 0);
    endtask

    // One configuration: run three periods and compare every cycle.
    task automatic run_cfg(input int dv, input int fd, input int rd);
        int dd, hh, fe, re, per, n, p;
        dd = (dv / 2) * 2;
        if (dd < 2) dd = 2;
        hh = dd / 2;
        fe = (fd == 0) ? 1 : ((fd > hh) ? hh : fd);
        re = (rd == 0) ? 1 : ((rd > hh) ? hh : rd);
        per = dd;
        n = 3 * per + 2;
        div_val     = 16'(dv);
        dly_word    = {16'(fd), 16'(rd)};
        stretch_lim = 16'd3;
        hold        = 1'b0;
        en          = 1'b1;
        check(scl_out == 1'b1, "R2 high before start", int'(scl_out), 1);
        for (int t = 1; t <= n; t++) begin
            step();
            p = (t - 1) % per;
            check(scl_out == (p >= hh), "R1 scl level", int'(scl_out), int'(p >= hh));
            check(upd_stb == (p == fe), "R3/R5 update strobe", int'(upd_stb), int'(p == fe));
            check(smp_stb == ((p == (hh + re) % per) && (t - 1 >= hh + re)),
                  "R4/R5 sample strobe", int'(smp_stb),
                  int'((p == (hh + re) % per) && (t - 1 >= hh + re)));
            check(!(upd_stb && smp_stb), "R9 strobes apart", int'(upd_stb && smp_stb), 0);
            check(stretch_to == 1'b0, "R7 no flag without stretch", int'(stretch_to), 0);
        end
        disable_and_check();
    endtask

    initial begin
        @(negedge clk);
        step();
        check(scl_out == 1'b1, "R8 reset scl", int'(scl_out), 1);
        check(!upd_stb && !smp_stb && !stretch_to, "R8 reset outputs",
              int'(upd_stb) + int'(smp_stb) + int'(stretch_to), 0);
        rst = 1'b0;
        step();

        // R2: the first edge after enable is a fall
        en = 1'b1;
        step();
        check(scl_out == 1'b0, "R2 first edge falls", int'(scl_out), 0);
        disable_and_check();

        // R1 R3 R4 R5 R9: sweep of small dividers and delays
        for (int dv = 0; dv <= 11; dv++)
            for (int fd = 0; fd <= 7; fd++)
                for (int rd = 0; rd <= 7; rd++)
                    run_cfg(dv, fd, rd);

        // R6 R7: stretch past a limit of 5, divider 8, delays 1
        div_val = 16'd8; dly_word = 32'h0001_0001; stretch_lim = 16'd5;
        hold = 1'b1; en = 1'b1;
        for (int t = 1; t <= 16; t++) begin
            step();
            if (t == 9)  check(stretch_to == 1'b0, "R7 flag not yet", int'(stretch_to), 0);
            if (t == 10) check(stretch_to == 1'b1, "R7 flag at limit", int'(stretch_to), 1);
            if (t >= 5 && t <= 12)
                check(smp_stb == 1'b0, "R6 no sample while held", int'(smp_stb), 0);
            if (t >= 5 && t <= 15)
                check(scl_out == 1'b1, "R6 stays released", int'(scl_out), 1);
            if (t == 12) hold = 1'b0;
            if (t == 13) check(smp_stb == 1'b1, "R4 sample after real rise", int'(smp_stb), 1);
            if (t == 16) begin
                check(scl_out == 1'b0, "R6 high phase resumes", int'(scl_out), 0);
                check(stretch_to == 1'b1, "R7 flag sticky", int'(stretch_to), 1);
            end
        end
        disable_and_check();

        // R7: short stretch below the limit
        hold = 1'b1; en = 1'b1;
        for (int t = 1; t <= 20; t++) begin
            step();
            if (t == 6) hold = 1'b0;
        end
        check(stretch_to == 1'b0, "R7 short stretch no flag", int'(stretch_to), 0);
        disable_and_check();

        // R7: limit zero never flags
        stretch_lim = 16'd0; hold = 1'b1; en = 1'b1;
        for (int t = 1; t <= 40; t++) step();
        check(stretch_to == 1'b0, "R7 zero limit", int'(stretch_to), 0);
        check(scl_out == 1'b1, "R6 held line keeps release", int'(scl_out), 1);
        hold = 1'b0;
        disable_and_check();

        finish_run();
    end

endmodule